// File: doc/BRIEF.md
# HDLC Receive Frame Buffer

This block sits between a serial HDLC receive channel and a processor bus. The channel hands over bytes one at a time, with an end-of-frame strobe that states whether the frame was clean. The block collects the bytes of one frame. It releases the frame to software only once that frame has ended cleanly, so the processor can read all of its bytes in one burst instead of servicing each byte as it arrives.

Software talks to the block through a small register window on a Wishbone-style slave port. A status and control register reports when a frame is waiting and when the buffer overflowed, and it carries a write-one drop command. A length register gives the size of the waiting frame until the first data read. Each read of the data register removes one byte. When a clean frame becomes available, a one-cycle interrupt pulse is raised.

The buffer holds a single frame at a time. Bytes and end strobes that arrive while a frame is waiting, or while an overflow is pending, are thrown away.

Top module: `hdlc_rxbuf`

## Requirements
- R1: After reset, the interrupt, the bus acknowledge and both status bits are 0, and the status register at address 3 reads 0.
- R2: A bus request (cyc and stb high) is acknowledged by a single-cycle pulse on wbAck, one clock after it is first seen. The read data is valid in that same cycle.
- R3: A clean end of frame (rxEop with rxBad low) that closes a frame of at least one byte sets the ready flag (status bit 0 at address 3). It also raises rxIrq for exactly one cycle.
- R4: The length register at address 4 returns the byte count of the waiting frame, from the moment ready is set until the first data read. After that read it returns 0.
- R5: Each acknowledged read of address 0 returns the next byte of the waiting frame, in arrival order. Reading the last byte clears the ready flag.
- R6: Reads of address 0 while the ready flag is clear return 0 and leave the buffer untouched.
- R7: A frame that ends with rxBad high is discarded. It raises no ready flag and no interrupt, and the next frame starts from an empty buffer.
- R8: A byte that arrives while the buffer already holds DEPTH bytes sets the overflow flag (status bit 1). Later bytes and end strobes are ignored until a drop command.
- R9: Writing 1 to bit 2 of address 3 clears the ready flag, the overflow flag and the stored length, and empties the buffer. Bit 2 always reads as 0.
- R10: Bytes and end strobes that arrive while a frame is waiting do not change the waiting frame.
- R11: An end of frame with no bytes stored sets no ready flag and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxByteValid | input | 1 | A received byte is present on rxByte |
| rxByte | input | 8 | Received byte |
| rxEop | input | 1 | End of the current frame |
| rxBad | input | 1 | With rxEop: the frame had a framing or check-sequence error |
| wbCyc | input | 1 | Bus cycle active |
| wbStb | input | 1 | Bus strobe |
| wbWe | input | 1 | Write enable |
| wbAdr | input | 3 | Register address: 0 data, 3 status/control, 4 length |
| wbDatI | input | 8 | Write data |
| wbDatO | output | 8 | Read data |
| wbAck | output | 1 | Bus acknowledge |
| rxIrq | output | 1 | One-cycle pulse when a frame becomes ready |

## Verification
The hardest case to reach is overflow. It needs one byte more than the buffer depth in a single frame, followed by an end strobe that has to be ignored, and only then a drop command. The stimulus sends DEPTH+1 bytes and then a clean end strobe. It checks that no interrupt appears and that status reads back as overflow only. It then drops the frame and sends one more small frame, to show the buffer really was emptied. The length window is tested the same way, by reading the length register both before and after the first data pop.

// File: rtl/hdlc_rxbuf_pkg.sv
package hdlc_rxbuf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } bufStrobes_t;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_LEN  = 3'd4;

  localparam int BIT_READY = 0;
  localparam int BIT_OVF   = 1;
  localparam int BIT_DROP  = 2;
endpackage

// File: rtl/hdlc_rxbuf_dp.sv
module hdlc_rxbuf_dp
  import hdlc_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  bufStrobes_t   strobes,
  input  logic [DW-1:0] wrByte,
  output logic [DW-1:0] rdByte
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtr + AW'(1);
      if (strobes.pop)  rdPtr <= rdPtr + AW'(1);
    end
  end

  assign rdByte = mem[rdPtr];

  // A frame is either being filled or being drained, never both.
  assert_no_push_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.push && strobes.pop));
endmodule

// File: rtl/hdlc_rxbuf_ctrl.sv
module hdlc_rxbuf_ctrl
  import hdlc_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxByteValid,
  input  logic          rxEop,
  input  logic          rxBad,
  input  logic          wbCyc,
  input  logic          wbStb,
  input  logic          wbWe,
  input  logic [2:0]    wbAdr,
  input  logic [DW-1:0] wbDatI,
  input  logic [DW-1:0] rdByte,
  output bufStrobes_t   strobes,
  output logic [DW-1:0] wbDatO,
  output logic          wbAck,
  output logic          rxIrq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic          rxReady, overflow, lenValid;
  logic [LW-1:0] count, lenReg, frameLen;
  logic          busReq, dataRd, dropWr, accept, full;
  logic          ovfHit, eopSeen, eopGood, eopBad, lastPop;
  logic [DW-1:0] rdMux;

  assign busReq   = wbCyc && wbStb && !wbAck;
  assign dropWr   = busReq && wbWe && (wbAdr == ADDR_CTRL) && wbDatI[BIT_DROP];
  assign dataRd   = busReq && !wbWe && (wbAdr == ADDR_DATA) && rxReady;
  assign accept   = !rxReady && !overflow && !dropWr;
  assign full     = (count == LW'(DEPTH));
  assign ovfHit   = accept && rxByteValid && full;
  assign eopSeen  = accept && rxEop && !ovfHit;
  assign frameLen = count + LW'(strobes.push);
  assign eopGood  = eopSeen && !rxBad && (frameLen != '0);
  assign eopBad   = eopSeen && (rxBad || (frameLen == '0));
  assign lastPop  = dataRd && (count == LW'(1));

  assign strobes.push  = accept && rxByteValid && !full;
  assign strobes.pop   = dataRd;
  assign strobes.flush = dropWr || eopBad || lastPop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      rxReady  <= 1'b0;
      overflow <= 1'b0;
      lenReg   <= '0;
      lenValid <= 1'b0;
      rxIrq    <= 1'b0;
    end else begin
      rxIrq <= eopGood;
      if (strobes.flush)     count <= '0;
      else if (strobes.push) count <= count + LW'(1);
      else if (strobes.pop)  count <= count - LW'(1);

      if (dropWr || lastPop) rxReady <= 1'b0;
      else if (eopGood)      rxReady <= 1'b1;

      if (dropWr)      overflow <= 1'b0;
      else if (ovfHit) overflow <= 1'b1;

      if (dropWr)       lenReg <= '0;
      else if (eopGood) lenReg <= frameLen;

      if (dropWr || dataRd) lenValid <= 1'b0;
      else if (eopGood)     lenValid <= 1'b1;
    end
  end

  always_comb begin
    rdMux = '0;
    case (wbAdr)
      ADDR_DATA: rdMux = rxReady ? rdByte : '0;
      ADDR_CTRL: begin
        rdMux[BIT_READY] = rxReady;
        rdMux[BIT_OVF]   = overflow;
      end
      ADDR_LEN:  rdMux = lenValid ? DW'(lenReg) : '0;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbAck  <= 1'b0;
      wbDatO <= '0;
    end else begin
      wbAck <= busReq;
      if (busReq) wbDatO <= wbWe ? '0 : rdMux;
    end
  end

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);
  assert_irq_with_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> rxReady);
  assert_ready_nonempty_R5: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> (count != '0));
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> (count != '0));
  assert_no_ovf_with_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(rxReady && overflow));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    count <= LW'(DEPTH));
  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    dropWr |=> (!rxReady && !overflow && !lenValid));
  assert_held_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && !strobes.pop && !dropWr) |=> $stable(count));
endmodule

// File: rtl/hdlc_rxbuf.sv
module hdlc_rxbuf
  import hdlc_rxbuf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxByteValid,
  input  logic [7:0] rxByte,
  input  logic       rxEop,
  input  logic       rxBad,
  input  logic       wbCyc,
  input  logic       wbStb,
  input  logic       wbWe,
  input  logic [2:0] wbAdr,
  input  logic [7:0] wbDatI,
  output logic [7:0] wbDatO,
  output logic       wbAck,
  output logic       rxIrq
);
  localparam int DW = 8;

  bufStrobes_t   strobes;
  logic [DW-1:0] rdByte;

  hdlc_rxbuf_ctrl #(.DEPTH(DEPTH), .DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .rxByteValid(rxByteValid), .rxEop(rxEop), .rxBad(rxBad),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr), .wbDatI(wbDatI),
    .rdByte(rdByte), .strobes(strobes),
    .wbDatO(wbDatO), .wbAck(wbAck), .rxIrq(rxIrq)
  );

  hdlc_rxbuf_dp #(.DEPTH(DEPTH), .DW(DW)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrByte(rxByte), .rdByte(rdByte)
  );
endmodule

// File: tb/hdlc_rxbuf_tb_top.sv
module hdlc_rxbuf_tb_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxByteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       rxEop = 1'b0;
  logic       rxBad = 1'b0;
  logic       wbCyc = 1'b0;
  logic       wbStb = 1'b0;
  logic       wbWe = 1'b0;
  logic [2:0] wbAdr = '0;
  logic [7:0] wbDatI = '0;
  logic [7:0] wbDatO;
  logic       wbAck;
  logic       rxIrq;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #10 clk = ~clk;

  hdlc_rxbuf #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares every read acknowledge against the scoreboard.
  always @(negedge clk) begin
    if (rstN && wbAck && !wbWe) begin
      if (expQ.size() == 0) chk("R2 unexpected ack", 1, 0);
      else chk(tagQ.pop_front(), wbDatO, expQ.pop_front());
    end
  end

  task automatic wbRead(logic [2:0] adr, logic [7:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 0; wbAdr = adr;
    @(posedge clk);
    @(negedge clk);
    chk("R2 ack high", wbAck, 1);
    wbCyc = 0; wbStb = 0;
    @(negedge clk);
    chk("R2 ack single", wbAck, 0);
  endtask

  task automatic wbWrite(logic [2:0] adr, logic [7:0] d);
    @(negedge clk);
    wbCyc = 1; wbStb = 1; wbWe = 1; wbAdr = adr; wbDatI = d;
    @(posedge clk);
    @(negedge clk);
    chk("R2 write ack", wbAck, 1);
    wbCyc = 0; wbStb = 0;
    @(negedge clk);
    wbWe = 0;
  endtask

  task automatic rxPut(logic [7:0] d);
    @(negedge clk);
    rxByteValid = 1; rxByte = d;
    @(negedge clk);
    rxByteValid = 0;
  endtask

  task automatic rxEnd(bit bad, bit expIrq, string tag);
    @(negedge clk);
    rxEop = 1; rxBad = bad;
    @(negedge clk);
    rxEop = 0; rxBad = 0;
    chk(tag, rxIrq, expIrq);
    @(negedge clk);
    chk("R3 irq one cycle", rxIrq, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 irq after reset", rxIrq, 0);
    chk("R1 ack after reset", wbAck, 0);
    wbRead(3'd3, 8'h00, "R1 status after reset");

    // Clean three-byte frame
    rxPut(8'hA1); rxPut(8'hB2); rxPut(8'hC3);
    rxEnd(0, 1, "R3 irq on clean end");
    wbRead(3'd3, 8'h01, "R3 ready bit");
    wbRead(3'd4, 8'h03, "R4 length in window");
    wbRead(3'd0, 8'hA1, "R5 byte 0");
    wbRead(3'd4, 8'h00, "R4 length after first pop");
    wbRead(3'd0, 8'hB2, "R5 byte 1");
    wbRead(3'd0, 8'hC3, "R5 byte 2");
    wbRead(3'd3, 8'h00, "R5 ready cleared after last byte");
    wbRead(3'd0, 8'h00, "R6 read while not ready");

    // Traffic while a frame waits
    rxPut(8'h11); rxPut(8'h22);
    rxEnd(0, 1, "R3 irq second frame");
    rxPut(8'h33); rxPut(8'h44);
    rxEnd(0, 0, "R10 no irq while held");
    wbRead(3'd4, 8'h02, "R10 length unchanged");
    wbRead(3'd0, 8'h11, "R10 byte 0");
    wbRead(3'd0, 8'h22, "R10 byte 1");
    wbRead(3'd3, 8'h00, "R10 nothing queued behind");

    // Bad frame then good frame
    rxPut(8'h55); rxPut(8'h66);
    rxEnd(1, 0, "R7 no irq on bad end");
    wbRead(3'd3, 8'h00, "R7 status after bad end");
    wbRead(3'd0, 8'h00, "R6 read after bad end");
    rxPut(8'h77);
    rxEnd(0, 1, "R7 irq on next frame");
    wbRead(3'd4, 8'h01, "R7 fresh length");
    wbRead(3'd0, 8'h77, "R7 fresh data");

    // Empty frame
    rxEnd(0, 0, "R11 no irq on empty frame");
    wbRead(3'd3, 8'h00, "R11 status after empty frame");

    // Overflow
    for (int i = 0; i <= DEPTH; i++) rxPut(8'(i + 8'h80));
    wbRead(3'd3, 8'h02, "R8 overflow bit");
    rxEnd(0, 0, "R8 end ignored during overflow");
    wbRead(3'd3, 8'h02, "R8 overflow sticky");
    wbWrite(3'd3, 8'h04);
    wbRead(3'd3, 8'h00, "R9 drop clears overflow");
    rxPut(8'h99);
    rxEnd(0, 1, "R9 irq after drop");
    wbRead(3'd4, 8'h01, "R9 length after drop");
    wbRead(3'd0, 8'h99, "R9 buffer emptied by drop");

    // Drop a waiting frame
    rxPut(8'hAA); rxPut(8'hBB);
    rxEnd(0, 1, "R3 irq before drop");
    wbWrite(3'd3, 8'h04);
    wbRead(3'd3, 8'h00, "R9 ready cleared by drop");
    wbRead(3'd4, 8'h00, "R9 length cleared by drop");
    wbRead(3'd0, 8'h00, "R9 no data after drop");
    rxPut(8'hCC);
    rxEnd(0, 1, "R9 irq after second drop");
    wbRead(3'd0, 8'hCC, "R9 fresh frame after drop");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule